// File: doc/BRIEF.md
# Multi-Channel Voltage-DAC Register Controller

This block is the digital control core of a four- or eight-channel, 10-bit voltage-output converter that is loaded through a parallel write port. Each channel holds an input register, an output register and an 8-bit trim code. A host writes new codes into the input registers one channel at a time. A single active-low load strobe then moves every input register into its output register in the same clock cycle, so all analog outputs change together.

A system register holds a power-down bit, a standby bit, a clear action and the input-coding mode. Each channel register holds a standby bit, a clear action and a bias-source select. A cleared channel returns to the bias point (code 200h) with its trim at midscale (80h). Input codes in twos-complement mode are converted to straight offset binary on the way in. The block drives per-channel codes, trim codes, bias selects and power-enable flags to the analog section. All inputs are synchronous to `clk`.

Top module: `dac_reg_ctrl`

## Requirements
- R1: A write commits on the first clock edge at which `wr_n` is seen high after being low, provided `cs_n` was low at the edge before. It uses the `reg_sel`, `addr` and `din` values sampled at that earlier edge. A strobe given while `cs_n` is high changes nothing.
- R2: A write with `reg_sel`=00 updates only the addressed channel's input register. `dac_code` for that channel keeps its old value until a load.
- R3: In every cycle in which `load_n` is low, every channel's output register takes its input register's value. While `load_n` is high, outputs hold.
- R4: System bit 3 selects the coding. When it is 1, a main-data write stores `din` with bit 9 inverted (twos complement to offset binary). When it is 0, `din` is stored unchanged. The mode is applied at the time of the write.
- R5: A write with `reg_sel`=01 sets the addressed channel's `trim_code` to `din[7:0]` at once, with no load needed.
- R6: A write with `reg_sel`=10 sets that channel's standby from `din[0]` and its bias select from `din[3:2]`. The bias select drives `bias_sel[2i+1:2i]`.
- R7: The system register is written with `reg_sel`=11 and holds power-down in bit 0 and standby in bit 1. `ch_active[i]` is low when power-down, system standby or channel i's standby is set. `ref_en` is low only under power-down.
- R8: A channel-register write with `din[1]`=1 sets that channel's input and output codes to 200h and its trim to 80h. Other channels are unaffected, and the clear bit is not kept.
- R9: A system write with `din[2]`=1 clears every channel as in R8.
- R10: While `clr_n` is low, every channel is held cleared as in R8. Control bits are kept.
- R11: After reset every code is 200h and every trim is 80h. All control bits are 0, so every channel is active with bias select 00 and `ref_en` is 1.
- R12: Writes to an address at or above the channel count have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe, commits on its rising edge |
| reg_sel | input | 2 | 00 main data, 01 trim, 10 channel control, 11 system |
| addr | input | ADDR_W | Channel address |
| din | input | CODE_W | Write data |
| load_n | input | 1 | Active-low simultaneous load of all outputs |
| clr_n | input | 1 | Active-low hardware clear of all channel codes |
| dac_code | output | N_CH*CODE_W | Offset-binary output codes, channel i at [10i+9:10i] |
| trim_code | output | N_CH*TRIM_W | Per-channel trim codes |
| bias_sel | output | N_CH*2 | Per-channel bias-source selects |
| ch_active | output | N_CH | Per-channel power-enable flags |
| ref_en | output | 1 | Reference enable |

## Verification
If the input register of a channel is wrong, nothing shows at the ports until the next load pulse. After that pulse the bad code appears on `dac_code` one edge later. The bench therefore follows every data write with a load and a check, and sweeps codes across all channels in both coding modes. Control state shows at once, because `ch_active`, `bias_sel` and `ref_en` follow their registers in the same cycle. A clear that reaches the wrong channels shows on the very next edge, both as codes that should have stayed put and as trims that moved.

// File: rtl/dac_ctl_pkg.sv
package dac_ctl_pkg;
   typedef enum logic [1:0] {
      SEL_MAIN = 2'b00,
      SEL_TRIM = 2'b01,
      SEL_CHAN = 2'b10,
      SEL_SYS  = 2'b11
   } regsel_e;

   // channel control field positions
   localparam int CTL_STBY    = 0;
   localparam int CTL_CLR     = 1;
   localparam int CTL_BIAS_LO = 2;
   // system control field positions
   localparam int SYS_PD   = 0;
   localparam int SYS_STBY = 1;
   localparam int SYS_CLR  = 2;
   localparam int SYS_TWOS = 3;
endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
   import dac_ctl_pkg::*;
#(
   parameter int N_CH   = 4,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic [1:0]        sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [N_CH-1:0]   we_main,
   output logic [N_CH-1:0]   we_trim,
   output logic [N_CH-1:0]   we_chan,
   output logic              we_sys,
   output logic [DATA_W-1:0] wdata
);
   logic              wr_q, cs_q;
   logic [1:0]        sel_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] din_q;
   logic              commit;
   regsel_e           kind;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= 1'b1;
         cs_q   <= 1'b1;
         sel_q  <= '0;
         addr_q <= '0;
         din_q  <= '0;
      end else begin
         wr_q   <= wr_n;
         cs_q   <= cs_n;
         sel_q  <= sel;
         addr_q <= addr;
         din_q  <= din;
      end
   end

   assign commit = !wr_q && wr_n && !cs_q;
   assign kind   = regsel_e'(sel_q);
   assign wdata  = din_q;
   assign we_sys = commit && (kind == SEL_SYS);

   for (genvar i = 0; i < N_CH; i++) begin : g_dec
      logic hit;
      assign hit        = commit && (addr_q == ADDR_W'(i));
      assign we_main[i] = hit && (kind == SEL_MAIN);
      assign we_trim[i] = hit && (kind == SEL_TRIM);
      assign we_chan[i] = hit && (kind == SEL_CHAN);
   end

   assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({we_main, we_trim, we_chan, we_sys}));
   assert_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n) |-> !(|{we_main, we_trim, we_chan, we_sys}));
endmodule

// File: rtl/dac_sys_reg.sv
module dac_sys_reg
   import dac_ctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [3:0] wbits,
   output logic       pd,
   output logic       sstby,
   output logic       twos,
   output logic       clr_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd    <= 1'b0;
         sstby <= 1'b0;
         twos  <= 1'b0;
      end else if (we) begin
         pd    <= wbits[SYS_PD];
         sstby <= wbits[SYS_STBY];
         twos  <= wbits[SYS_TWOS];
      end
   end

   assign clr_pulse = we && wbits[SYS_CLR];

   assert_sys_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable({pd, sstby, twos}));
endmodule

// File: rtl/dac_chan.sv
module dac_chan
   import dac_ctl_pkg::*;
#(
   parameter int CODE_W = 10,
   parameter int TRIM_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glob_clr,
   input  logic              we_main,
   input  logic              we_trim,
   input  logic              we_chan,
   input  logic [CODE_W-1:0] wdata,
   input  logic              twos,
   input  logic              load,
   input  logic              pd,
   input  logic              sstby,
   output logic [CODE_W-1:0] code,
   output logic [TRIM_W-1:0] trim,
   output logic [1:0]        bias,
   output logic              active
);
   localparam logic [CODE_W-1:0] MID      = CODE_W'(1) << (CODE_W-1);
   localparam logic [TRIM_W-1:0] TRIM_MID = TRIM_W'(1) << (TRIM_W-1);

   logic [CODE_W-1:0] data_q, dac_q, conv;
   logic [TRIM_W-1:0] sub_q;
   logic              stby_q, clr_here;
   logic [1:0]        bias_q;

   assign clr_here = glob_clr || (we_chan && wdata[CTL_CLR]);
   assign conv     = twos ? {~wdata[CODE_W-1], wdata[CODE_W-2:0]} : wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= MID;
         dac_q  <= MID;
         sub_q  <= TRIM_MID;
         stby_q <= 1'b0;
         bias_q <= 2'b00;
      end else begin
         if (we_chan) begin
            stby_q <= wdata[CTL_STBY];
            bias_q <= wdata[CTL_BIAS_LO +: 2];
         end
         if (clr_here) begin
            data_q <= MID;
            dac_q  <= MID;
            sub_q  <= TRIM_MID;
         end else begin
            if (we_main) data_q <= conv;
            if (we_trim) sub_q  <= wdata[TRIM_W-1:0];
            if (load)    dac_q  <= data_q;
         end
      end
   end

   assign code   = dac_q;
   assign trim   = sub_q;
   assign bias   = bias_q;
   assign active = !(pd || sstby || stby_q);

   assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr_here) |=> (dac_q == $past(data_q)));
   assert_hold_no_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !clr_here) |=> $stable(dac_q));
   assert_clear_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_here |=> (dac_q == MID && data_q == MID && sub_q == TRIM_MID));
endmodule

// File: rtl/dac_reg_ctrl.sv
module dac_reg_ctrl
   import dac_ctl_pkg::*;
#(
   parameter int N_CH   = 4,
   parameter int CODE_W = 10,
   parameter int TRIM_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     wr_n,
   input  logic [1:0]               reg_sel,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [CODE_W-1:0]        din,
   input  logic                     load_n,
   input  logic                     clr_n,
   output logic [N_CH*CODE_W-1:0]   dac_code,
   output logic [N_CH*TRIM_W-1:0]   trim_code,
   output logic [N_CH*2-1:0]        bias_sel,
   output logic [N_CH-1:0]          ch_active,
   output logic                     ref_en
);
   if (!(N_CH == 4 || N_CH == 8)) begin : g_bad_nch
      $error("N_CH must be 4 or 8");
   end
   if ((1 << ADDR_W) < N_CH) begin : g_bad_addr
      $error("ADDR_W too narrow for N_CH");
   end
   if (CODE_W < 4 || TRIM_W > CODE_W) begin : g_bad_width
      $error("CODE_W must be >= 4 and >= TRIM_W");
   end

   logic [N_CH-1:0]   we_main, we_trim, we_chan;
   logic              we_sys, pd, sstby, twos, sys_clr, glob_clr;
   logic [CODE_W-1:0] wdata;

   dac_wr_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(CODE_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .sel(reg_sel),
      .addr(addr), .din(din), .we_main(we_main), .we_trim(we_trim),
      .we_chan(we_chan), .we_sys(we_sys), .wdata(wdata));

   dac_sys_reg u_sys (
      .clk(clk), .rst_n(rst_n), .we(we_sys), .wbits(wdata[3:0]),
      .pd(pd), .sstby(sstby), .twos(twos), .clr_pulse(sys_clr));

   assign glob_clr = !clr_n || sys_clr;
   assign ref_en   = !pd;

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      dac_chan #(.CODE_W(CODE_W), .TRIM_W(TRIM_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .glob_clr(glob_clr),
         .we_main(we_main[i]), .we_trim(we_trim[i]), .we_chan(we_chan[i]),
         .wdata(wdata), .twos(twos), .load(!load_n), .pd(pd), .sstby(sstby),
         .code(dac_code[i*CODE_W +: CODE_W]),
         .trim(trim_code[i*TRIM_W +: TRIM_W]),
         .bias(bias_sel[i*2 +: 2]),
         .active(ch_active[i]));
   end

   assert_power_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pd || sstby) |-> (ch_active == '0));
endmodule

// File: tb/tb_dac_reg_ctrl.sv
`timescale 1ns/1ps
module tb_dac_reg_ctrl;
   localparam int NC = 4;
   logic clk = 0, rst_n = 0, cs_n = 1, wr_n = 1, load_n = 1, clr_n = 1;
   logic [1:0] reg_sel = 0;
   logic [2:0] addr = 0;
   logic [9:0] din = 0;
   logic [NC*10-1:0] dac_code;
   logic [NC*8-1:0]  trim_code;
   logic [NC*2-1:0]  bias_sel;
   logic [NC-1:0]    ch_active;
   logic             ref_en;

   int nerr = 0, nchk = 0;
   int md[NC], mq[NC], ms[NC], mstb[NC], mbias[NC];
   int mpd = 0, mst = 0, mtw = 0;

   always #2.5 clk = ~clk;

   dac_reg_ctrl dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
      .reg_sel(reg_sel), .addr(addr), .din(din), .load_n(load_n), .clr_n(clr_n),
      .dac_code(dac_code), .trim_code(trim_code), .bias_sel(bias_sel),
      .ch_active(ch_active), .ref_en(ref_en));

   task automatic chk(string tag, int got, int exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic check_all(string tag);
      for (int c = 0; c < NC; c++) begin
         chk(tag, int'(dac_code[c*10 +: 10]), mq[c]);
         chk(tag, int'(trim_code[c*8 +: 8]), ms[c]);
         chk(tag, int'(bias_sel[c*2 +: 2]), mbias[c]);
         chk(tag, int'(ch_active[c]), (mpd | mst | mstb[c]) ? 0 : 1);
      end
      chk(tag, int'(ref_en), mpd ? 0 : 1);
   endtask

   task automatic wr(int sel, int a, int d, bit sel_chip = 1);
      @(negedge clk);
      cs_n = !sel_chip; wr_n = 0; reg_sel = 2'(sel); addr = 3'(a); din = 10'(d);
      @(negedge clk);
      wr_n = 1;
      @(negedge clk);
      cs_n = 1;
   endtask

   task automatic load();
      @(negedge clk); load_n = 0;
      @(negedge clk); load_n = 1;
      for (int c = 0; c < NC; c++) mq[c] = md[c];
   endtask

   task automatic clear_model(int c);
      md[c] = 'h200; mq[c] = 'h200; ms[c] = 'h80;
   endtask

   task automatic sys_w(int pd, int st, int clr, int tw);
      wr(3, 0, (tw << 3) | (clr << 2) | (st << 1) | pd);
      mpd = pd; mst = st; mtw = tw;
      if (clr) for (int c = 0; c < NC; c++) clear_model(c);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      for (int c = 0; c < NC; c++) begin
         clear_model(c); mstb[c] = 0; mbias[c] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check_all("R11 reset state");

      // R2: write without load leaves outputs alone
      for (int c = 0; c < NC; c++) begin
         wr(0, c, 'h11 * (c + 1));
         md[c] = 'h11 * (c + 1);
      end
      check_all("R2 no load yet");
      // R3: simultaneous load
      load();
      check_all("R3 load all");

      // R4: coding sweep in both modes
      for (int tw = 0; tw < 2; tw++) begin
         sys_w(0, 0, 0, tw);
         for (int v = 0; v < 1024; v += 37) begin
            int c = (v / 37) % NC;
            wr(0, c, v);
            md[c] = tw ? (v ^ 'h200) : v;
            load();
            check_all(tw ? "R4 twos coding" : "R4 binary coding");
         end
      end
      // R4 twos-complement most negative gives zero-scale
      wr(0, 1, 'h200); md[1] = 0; load();
      check_all("R4 twos zero scale");
      sys_w(0, 0, 0, 0);

      // R5: trim sweep, no load needed
      for (int t = 0; t < 256; t += 17) begin
         int c = (t / 17) % NC;
         wr(1, c, t); ms[c] = t;
         check_all("R5 trim write");
      end

      // R6/R7: channel control
      for (int c = 0; c < NC; c++) begin
         wr(2, c, ((c % 4) << 2) | (c & 1));
         mbias[c] = c % 4; mstb[c] = c & 1;
         check_all("R6 channel control");
      end
      sys_w(1, 0, 0, 0); check_all("R7 power down");
      sys_w(0, 1, 0, 0); check_all("R7 system standby");
      sys_w(0, 0, 0, 0); check_all("R7 all released");

      // R12: out-of-range addresses
      for (int a = NC; a < 8; a++) begin
         wr(0, a, 'h3FF); wr(1, a, 'h55); wr(2, a, 'hF);
      end
      load();
      check_all("R12 out of range ignored");

      // R1: strobe without chip select
      wr(0, 0, 'h123, 0); wr(1, 0, 'h12, 0); load();
      check_all("R1 no chip select");

      // R8: channel clear on channel 2 only
      wr(2, 2, 'b1110);
      clear_model(2); mbias[2] = 3; mstb[2] = 0;
      check_all("R8 channel clear");
      load();
      check_all("R8 clear bit not kept");

      // R9: system clear
      wr(0, 0, 'h3AB); md[0] = 'h3AB; load();
      sys_w(0, 0, 1, 0);
      check_all("R9 system clear");

      // R10: hardware clear keeps control
      for (int c = 0; c < NC; c++) begin wr(0, c, 'h3C + c); md[c] = 'h3C + c; end
      wr(1, 3, 'h9); ms[3] = 'h9;
      load();
      check_all("R10 before clear");
      @(negedge clk); clr_n = 0;
      @(negedge clk); clr_n = 1;
      for (int c = 0; c < NC; c++) clear_model(c);
      check_all("R10 hardware clear");

      summary();
      $finish;
   end
endmodule